// File: doc/BRIEF.md
# Phase-Shift Full-Bridge Gate Sequencer

This block turns a single-ended pulse train into the four gate-drive enables of a full-bridge power stage. Switches A and B form the left leg and C and D the right leg. Each rising edge of the pulse input flips a toggle, and the toggle drives the left leg at half the pulse rate. The right leg is the toggle XORed with a registered copy of the pulse input. It is therefore a copy of the left leg that lags by the pulse high time. Power flows while a diagonal pair (A with D, or B with C) conducts. The bridge freewheels while A with C, or B with D, conduct together. The effective duty is set only by how long the pulse stays high, and the switching frequency does not change.

Each leg has its own glitch filter, which discards any level change shorter than a programmable width. Each leg also has its own turn-on delay. A switch turns on only after its partner in the same leg has been off for the programmed number of clocks. Turn-off is not delayed. An output interlock forces all four enables low if both switches of one leg are ever requested together, and it latches a fault flag that only reset clears. All four enables stay low in reset and while the enable input is low. After enable, nothing moves until the first rising edge of the pulse input.

Cycle numbering used below: "edge n" is the first clock edge that samples a new pulse-input level. An output is "visible in cycle k" when it holds its new value after clock edge k. G, NL and NR are the glitch width and the two dead times, and a setting of 0 acts as 1.

Top module: `psfb_gate_seq`

## Requirements
- R1: While rst_n is low, and one clock after en is sampled low, gate_a, gate_b, gate_c and gate_d are all 0 and fault is 0.
- R2: After en rises, all four gates stay 0 until the first pulse rise. For that first rise at edge n0, gate_a becomes visible in cycle n0+1+G+NL and gate_d in cycle n0+1+G+NR.
- R3: Each later pulse rise at edge n toggles the left leg, so the left leg runs at half the pulse rate. The left switch that was on is seen low from cycle n+2+G. After the i-th rise (counting from 0), A is the selected left switch when i is even and B when i is odd.
- R4: Each pulse fall at edge m toggles the right leg. The right switch that was on is seen low from cycle m+2+G, so right-leg transitions trail left-leg transitions by exactly the pulse high time. After the j-th fall (counting from 0), C is the selected right switch when j is even and D when j is odd.
- R5: In the left leg, the incoming switch rises only after both switches have been low for exactly NL cycles. It is visible in cycle n+2+G+NL.
- R6: In the right leg, the incoming switch rises only after both switches have been low for exactly NR cycles. It is visible in cycle m+2+G+NR.
- R7: A change of a leg's requested state that lasts fewer than G cycles produces no change on that leg's gates. For example, two pulse rises two clocks apart with G of at least 3 leave all four gates unchanged.
- R8: gate_a and gate_b are never high together, and neither are gate_c and gate_d. If a leg's request ever had both switches high, all gates would be forced low and fault would stay set until reset. In normal operation fault stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears the sequencer |
| pwm_in | input | 1 | Single-ended pulse train at the converter rate, synchronous to clk |
| dead_left | input | CNT_W | Left-leg turn-on delay in clocks (0 acts as 1) |
| dead_right | input | CNT_W | Right-leg turn-on delay in clocks (0 acts as 1) |
| glitch_min | input | CNT_W | Minimum accepted level duration in clocks (0 acts as 1) |
| gate_a | output | 1 | Left-leg upper switch enable |
| gate_b | output | 1 | Left-leg lower switch enable |
| gate_c | output | 1 | Right-leg upper switch enable |
| gate_d | output | 1 | Right-leg lower switch enable |
| fault | output | 1 | Sticky shoot-through fault flag |

## Verification
The hardest condition to reach from the ports is a leg whose request flips and flips back inside the glitch window. Ordinary pulse trains never produce it. The bench creates it on purpose: once the bridge has settled, it injects two pulse rises two clocks apart, with a glitch width of three or more. It then checks that none of the four gates moves for the whole dead-time window that follows. The exact turn-on delays at the very first arm, where only one switch per leg has ever been on, are a second awkward case. The bench measures them against each random mix of pulse period, high time, glitch width and dead times.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

    // Drive request for one leg: upper and lower switch.
    typedef struct packed {
        logic hi;
        logic lo;
    } leg_t;

endpackage

// File: rtl/psfb_phase_gen.sv
module psfb_phase_gen
    import psfb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pwm_in,
    output leg_t left_raw,
    output leg_t right_raw
);

    typedef struct packed {
        logic pwm;       // registered pulse input
        logic pwm_prev;  // one more stage, aligned with the toggle
        logic tgl;       // half-rate toggle
        logic armed;     // a rise has been seen since enable
    } st_t;

    st_t  q, d;
    logic rise;
    logic xr;

    assign rise = q.pwm & ~q.pwm_prev;

    always_comb begin
        d          = q;
        d.pwm      = pwm_in;
        d.pwm_prev = q.pwm;
        if (!en) begin
            d.tgl   = 1'b0;
            d.armed = 1'b0;
        end else if (rise) begin
            d.tgl   = ~q.tgl;
            d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Both legs come from the same register stage, so their latency matches.
    assign xr           = q.pwm_prev ^ q.tgl;
    assign left_raw.hi  = q.armed &  q.tgl;
    assign left_raw.lo  = q.armed & ~q.tgl;
    assign right_raw.hi = q.armed &  xr;
    assign right_raw.lo = q.armed & ~xr;

    // R3: the left request moves only in the cycle after a detected rise
    a_r3_left_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (left_raw != $past(left_raw))) |-> $past(q.pwm && !q.pwm_prev));

endmodule

// File: rtl/psfb_glitch_filt.sv
module psfb_glitch_filt
    import psfb_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] min_w,
    input  leg_t             raw,
    output leg_t             filt
);

    localparam int CW1 = CNT_W + 1;

    typedef struct packed {
        leg_t             val;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t            q, d;
    logic [CW1-1:0] nxt;

    assign nxt = {1'b0, q.cnt} + CW1'(1);

    always_comb begin
        d = q;
        if (clr) begin
            d.val = '0;
            d.cnt = '0;
        end else if (raw == q.val) begin
            d.cnt = '0;
        end else if (nxt >= {1'b0, min_w}) begin
            d.val = raw;
            d.cnt = '0;
        end else begin
            d.cnt = nxt[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign filt = q.val;

    // R7: a new filtered value is always the raw value seen the cycle before
    a_r7_filter_takes_raw: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.val != $past(q.val)) && !$past(clr)) |-> ($past(raw) == q.val));

endmodule

// File: rtl/psfb_leg_dead.sv
module psfb_leg_dead
    import psfb_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] dead,
    input  leg_t             req,
    output leg_t             drv
);

    localparam int CW1   = CNT_W + 1;
    localparam int SIDES = 2;

    // index 1 = upper switch, index 0 = lower switch
    typedef struct packed {
        logic [SIDES-1:0]            on;
        logic [SIDES-1:0][CNT_W-1:0] cnt;
    } st_t;

    st_t              q, d;
    logic [SIDES-1:0] req_v;

    assign req_v = {req.hi, req.lo};

    always_comb begin
        d = q;
        for (int s = 0; s < SIDES; s++) begin
            logic [CW1-1:0] nxt;
            logic           partner;
            nxt     = {1'b0, q.cnt[s]} + CW1'(1);
            partner = (s == 0) ? q.on[1] : q.on[0];
            if (clr || !req_v[s]) begin
                // turn-off is immediate
                d.on[s]  = 1'b0;
                d.cnt[s] = '0;
            end else if (q.on[s] || partner) begin
                d.cnt[s] = '0;
            end else if (nxt >= {1'b0, dead}) begin
                d.on[s]  = 1'b1;
                d.cnt[s] = '0;
            end else begin
                d.cnt[s] = nxt[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign drv.hi = q.on[1];
    assign drv.lo = q.on[0];

    // R5 / R6: a switch rises only while its partner was already off
    a_r5_r6_gap_upper: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv.hi) |-> (!$past(drv.lo) && !drv.lo));
    a_r5_r6_gap_lower: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv.lo) |-> (!$past(drv.hi) && !drv.hi));
    // R3 / R4: removing a request drops the switch on the next clock
    a_r3_r4_fast_off_upper: assert property (@(posedge clk) disable iff (!rst_n)
        !req.hi |=> !drv.hi);
    a_r3_r4_fast_off_lower: assert property (@(posedge clk) disable iff (!rst_n)
        !req.lo |=> !drv.lo);

endmodule

// File: rtl/psfb_interlock.sv
module psfb_interlock
    import psfb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  leg_t left,
    input  leg_t right,
    output logic gate_a,
    output logic gate_b,
    output logic gate_c,
    output logic gate_d,
    output logic fault
);

    typedef struct packed {
        logic fault;
    } st_t;

    st_t  q, d;
    logic overlap;
    logic block;

    assign overlap = (left.hi & left.lo) | (right.hi & right.lo);
    assign block   = q.fault | overlap;

    always_comb begin
        d       = q;
        d.fault = q.fault | overlap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign gate_a = left.hi  & ~block;
    assign gate_b = left.lo  & ~block;
    assign gate_c = right.hi & ~block;
    assign gate_d = right.lo & ~block;
    assign fault  = q.fault;

    // R8: the dead-time stages never request both switches of a leg
    a_r8_leg_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(left.hi && left.lo) && !(right.hi && right.lo));
    // R8: the fault flag is sticky
    a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.fault |=> q.fault);

endmodule

// File: rtl/psfb_gate_seq.sv
module psfb_gate_seq
    import psfb_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pwm_in,
    input  logic [CNT_W-1:0] dead_left,
    input  logic [CNT_W-1:0] dead_right,
    input  logic [CNT_W-1:0] glitch_min,
    output logic             gate_a,
    output logic             gate_b,
    output logic             gate_c,
    output logic             gate_d,
    output logic             fault
);

    localparam int LEGS = 2;   // 0 = left (A/B), 1 = right (C/D)

    leg_t             raw     [LEGS];
    leg_t             flt     [LEGS];
    leg_t             drv     [LEGS];
    logic [CNT_W-1:0] dead_v  [LEGS];
    logic             clr;

    assign clr       = ~en;
    assign dead_v[0] = dead_left;
    assign dead_v[1] = dead_right;

    psfb_phase_gen u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .pwm_in    (pwm_in),
        .left_raw  (raw[0]),
        .right_raw (raw[1])
    );

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        psfb_glitch_filt #(.CNT_W(CNT_W)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .min_w (glitch_min),
            .raw   (raw[g]),
            .filt  (flt[g])
        );

        psfb_leg_dead #(.CNT_W(CNT_W)) u_dead (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .dead  (dead_v[g]),
            .req   (flt[g]),
            .drv   (drv[g])
        );
    end

    psfb_interlock u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .left   (drv[0]),
        .right  (drv[1]),
        .gate_a (gate_a),
        .gate_b (gate_b),
        .gate_c (gate_c),
        .gate_d (gate_d),
        .fault  (fault)
    );

    // R1: a low enable clears every gate one clock later
    a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(gate_a || gate_b || gate_c || gate_d));

endmodule

// File: tb/psfb_gate_seq_tb_top.sv
module psfb_gate_seq_tb_top;

    localparam int CNT_W = 4;
    localparam int LOGN  = 4096;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             en;
    logic             pwm_in;
    logic [CNT_W-1:0] dead_left, dead_right, glitch_min;
    logic             gate_a, gate_b, gate_c, gate_d, fault;

    int   cyc = 0;
    int   base = 0;
    bit   logging = 1'b0;
    bit   done = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;
    logic [3:0] lg [LOGN];   // {A,B,C,D} per cycle

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk)
        if (logging && (cyc - base) < LOGN && (cyc - base) >= 0)
            lg[cyc - base] = {gate_a, gate_b, gate_c, gate_d};

    psfb_gate_seq #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .pwm_in(pwm_in),
        .dead_left(dead_left), .dead_right(dead_right), .glitch_min(glitch_min),
        .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c), .gate_d(gate_d),
        .fault(fault)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [3:0] at(input int abs_c);
        return lg[abs_c - base];
    endfunction

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // two consecutive samples of one gate bit, packed {first, second}
    function automatic int pair(input int c, input int b);
        logic [3:0] x0, x1;
        x0 = at(c);
        x1 = at(c + 1);
        return {30'd0, x0[b], x1[b]};
    endfunction

    function automatic int gates_now();
        return {28'd0, gate_a, gate_b, gate_c, gate_d};
    endfunction

    task automatic run_pattern(input int P, input int H, input int G,
                               input int NL, input int NR, input int NP);
        int gl, nle, nre, n, m, onb, offb, last;
        int rises [8];
        int falls [8];
        int snap, bad_v;
        bit ok;
        gl  = eff(G);
        nle = eff(NL);
        nre = eff(NR);

        @(negedge clk);
        en = 1'b0; pwm_in = 1'b0;
        dead_left = CNT_W'(NL); dead_right = CNT_W'(NR); glitch_min = CNT_W'(G);
        repeat (3) @(negedge clk);
        chk(gates_now() == 0 && fault == 1'b0, "R1 disabled idle", gates_now(), 0);

        en = 1'b1;
        base = cyc;
        logging = 1'b1;
        repeat (4) @(negedge clk);
        chk(gates_now() == 0, "R2 quiet before first rise", gates_now(), 0);

        for (int p = 0; p < NP; p++) begin
            pwm_in = 1'b1;
            rises[p] = cyc + 1;
            repeat (H) @(negedge clk);
            pwm_in = 1'b0;
            falls[p] = cyc + 1;
            repeat (P - H) @(negedge clk);
        end
        repeat (gl + nle + nre + 10) @(negedge clk);

        // first arm: A and D
        n = rises[0];
        chk(pair(n + gl + nle, 3) == 1, "R2 first A turn-on", pair(n + gl + nle, 3), 1);
        chk(pair(n + gl + nre, 0) == 1, "R2 first D turn-on", pair(n + gl + nre, 0), 1);

        for (int i = 1; i < NP; i++) begin
            n    = rises[i];
            onb  = (i % 2 == 0) ? 3 : 2;
            offb = (i % 2 == 0) ? 2 : 3;
            chk(pair(n + 1 + gl, offb) == 2, "R3 left turn-off", pair(n + 1 + gl, offb), 2);
            chk(pair(n + 1 + gl + nle, onb) == 1, "R5 left dead time",
                pair(n + 1 + gl + nle, onb), 1);
        end

        for (int j = 0; j < NP; j++) begin
            m    = rises[j] + H;   // right edges trail left by the high time
            onb  = (j % 2 == 0) ? 1 : 0;
            offb = (j % 2 == 0) ? 0 : 1;
            chk(m == falls[j], "R4 fall timing", falls[j], m);
            chk(pair(m + 1 + gl, offb) == 2, "R4 right turn-off", pair(m + 1 + gl, offb), 2);
            chk(pair(m + 1 + gl + nre, onb) == 1, "R6 right dead time",
                pair(m + 1 + gl + nre, onb), 1);
        end

        // no leg ever has both switches on
        ok = 1'b1; bad_v = 0;
        last = cyc - base;
        for (int k = 0; k <= last && k < LOGN; k++) begin
            if ((lg[k][3] && lg[k][2]) || (lg[k][1] && lg[k][0])) begin
                ok = 1'b0; bad_v = int'(lg[k]);
            end
        end
        chk(ok && fault == 1'b0, "R8 leg exclusion", bad_v, 0);

        // narrow double pulse must be swallowed by the filter
        if (gl >= 3) begin
            snap = gates_now();
            pwm_in = 1'b1; @(negedge clk);
            pwm_in = 1'b0; @(negedge clk);
            pwm_in = 1'b1; @(negedge clk);
            pwm_in = 1'b0;
            ok = 1'b1; bad_v = snap;
            repeat (gl + nle + nre + 8) begin
                @(negedge clk);
                if (gates_now() != snap) begin ok = 1'b0; bad_v = gates_now(); end
            end
            chk(ok, "R7 glitch rejected", bad_v, snap);
        end

        chk(gates_now() != 0, "R1 active before disable", gates_now(), 1);
        en = 1'b0;
        @(negedge clk);
        chk(gates_now() == 0, "R1 disable clears", gates_now(), 0);
        chk(fault == 1'b0, "R8 fault stays clear", int'(fault), 0);
        logging = 1'b0;
    endtask

    initial begin
        int unsigned seed;
        int g, nl, nr, hmin, P, H;
        seed = 32'd20240611;
        void'($urandom(seed));
        rst_n = 1'b0; en = 1'b0; pwm_in = 1'b0;
        dead_left = '0; dead_right = '0; glitch_min = '0;
        repeat (4) @(negedge clk);
        chk(gates_now() == 0 && fault == 1'b0, "R1 reset state", gates_now(), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed corners
        run_pattern(24, 12, 1, 7, 4, 5);   // longer left delay than right
        run_pattern(30, 8, 3, 2, 2, 5);    // filter at 3, glitch case
        run_pattern(20, 10, 0, 0, 0, 5);   // zero settings act as 1
        run_pattern(40, 6, 4, 3, 5, 6);    // short high time, wide filter

        for (int r = 0; r < 8; r++) begin
            g    = int'($urandom % 5);
            nl   = int'($urandom % 8);
            nr   = int'($urandom % 8);
            hmin = eff(g) + ((eff(nl) > eff(nr)) ? eff(nl) : eff(nr)) + 4;
            P    = 2 * hmin + int'($urandom % 10);
            H    = hmin + int'($urandom % (P - 2 * hmin + 1));
            run_pattern(P, H, g, nl, nr, 6);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule